// File: doc/BRIEF.md
# Debug Return Offset Tracker

While a processor core sits halted in debug state, every instruction the debugger pushes through it moves the program counter. This block counts that drift and turns it into the negative branch offset the debugger has to issue as its last instruction so that the core resumes exactly where the halted program stopped. It watches a debug-entry pulse with its cause, one strobe per debug-speed instruction, one strobe per system-speed instruction, an abort flag for system-speed memory accesses, and a prefetch-abort flag that arrives alongside a breakpointed fetch.

The cause of entry selects the base of the offset. Instructions run at system speed count three times. A breakpoint whose fetch also raised a prefetch abort is dropped, so the abort is handled first. An aborted system-speed access produces a request to take the abort-mode exception before the core goes back into debug state. The counts saturate, and an overflow marks the offset as unusable until the next entry.

Top module: `dbg_ret_tracker`

## Requirements
- R1: An accepted entry (`entry_i` high and not suppressed by R5) raises `entry_o` for exactly the following cycle, latches `cause_i`, and clears both instruction counts, so the next cycle shows the bare base offset.
- R2: With latched cause 2'b00 (breakpoint) or 2'b01 (watchpoint), `offset_o` is the 32-bit two's-complement value of -(4 + N + 3S), where N is the count of debug-speed strobes and S the count of system-speed strobes since the last accepted entry.
- R3: With latched cause 2'b10 (external debug request) or 2'b11 (watchpoint taken with an exception), `offset_o` is -(3 + N + 3S).
- R4: Each cycle with `dbg_instr_i` high adds one to N and each cycle with `sys_instr_i` high adds one to S, both in the same cycle when both are high; `offset_o` follows the counts in the cycle after the strobe.
- R5: An `entry_i` pulse with cause 2'b00 while `pf_abort_i` is high is ignored: no `entry_o`, and the cause and counts stay as they were. `pf_abort_i` has no effect on entries with any other cause.
- R6: A cycle with `sys_instr_i` and `sys_abort_i` both high raises `abort_req_o` for exactly the next cycle, and the access still counts in S; `sys_abort_i` without `sys_instr_i` is ignored.
- R7: N and S are 8-bit counts that stop at 255. A strobe arriving while its count is at 255 sets a sticky overflow that drives `offset_valid_o` low until the next accepted entry.
- R8: After reset, `entry_o` and `abort_req_o` are low, `offset_valid_o` is high, the cause is breakpoint and `offset_o` is 32'hFFFF_FFFC.
- R9: When an accepted entry and instruction strobes share a cycle, the entry wins and both counts restart at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| entry_i | input | 1 | Debug-entry pulse |
| cause_i | input | 2 | Entry cause, valid with `entry_i` |
| pf_abort_i | input | 1 | Prefetch abort on the breakpointed fetch |
| dbg_instr_i | input | 1 | One debug-speed instruction executed |
| sys_instr_i | input | 1 | One system-speed instruction executed |
| sys_abort_i | input | 1 | The system-speed access aborted |
| offset_o | output | 32 | Signed return branch offset |
| offset_valid_o | output | 1 | Low after a count overflow |
| entry_o | output | 1 | Debug entry accepted, one cycle |
| abort_req_o | output | 1 | Abort-mode request, one cycle |

## Verification
A wrong count or a wrongly latched cause is visible on `offset_o` in the cycle after the strobe or entry that caused it, because the offset is derived combinationally from the held state. A reference model in the bench therefore catches any drift in the counts, the weighting or the base on the very next clock. A missed clear, a lost suppression or a stuck overflow shows up either on `entry_o` one cycle later or on `offset_o` and `offset_valid_o` as soon as the next strobe arrives.

// File: rtl/dbg_ret_pkg.sv
package dbg_ret_pkg;
  typedef enum logic [1:0] {
    CAUSE_BKPT    = 2'b00,
    CAUSE_WPT     = 2'b01,
    CAUSE_DREQ    = 2'b10,
    CAUSE_WPT_EXC = 2'b11
  } cause_e;

  // base 3 for the asynchronous causes, 4 for the synchronous ones
  function automatic logic [2:0] cause_base(cause_e c);
    return c[1] ? 3'd3 : 3'd4;
  endfunction
endpackage

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_ret_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       entry_i,
  input  logic [1:0] cause_i,
  input  logic       pf_abort_i,
  output logic       accept_o,
  output cause_e     cause_q_o,
  output logic       entry_o
);
  logic suppress;

  // prefetch abort outranks a breakpoint only
  assign suppress = pf_abort_i && (cause_e'(cause_i) == CAUSE_BKPT);
  assign accept_o = entry_i && !suppress;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q_o <= CAUSE_BKPT;
      entry_o   <= 1'b0;
    end else begin
      entry_o <= accept_o;
      if (accept_o) cause_q_o <= cause_e'(cause_i);
    end
  end
endmodule

// File: rtl/dbg_sat_cnt.sv
module dbg_sat_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         sat_hit_o
);
  localparam logic [W-1:0] MaxVal = {W{1'b1}};

  assign sat_hit_o = inc_i && !clr_i && (cnt_o == MaxVal);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_o <= '0;
    else if (clr_i)                         cnt_o <= '0;
    else if (inc_i && (cnt_o != MaxVal))    cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dbg_offset_calc.sv
module dbg_offset_calc
  import dbg_ret_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned OFF_W = 32
) (
  input  cause_e             cause_i,
  input  logic [CNT_W-1:0]   n_i,
  input  logic [CNT_W-1:0]   s_i,
  output logic [OFF_W-1:0]   offset_o
);
  logic [OFF_W-1:0] base_w, n_w, s_w, sum;

  always_comb begin
    base_w   = OFF_W'(cause_base(cause_i));
    n_w      = OFF_W'(n_i);
    s_w      = OFF_W'(s_i);
    sum      = base_w + n_w + s_w + (s_w << 1);
    offset_o = OFF_W'(0) - sum;
  end
endmodule

// File: rtl/dbg_ret_tracker.sv
module dbg_ret_tracker
  import dbg_ret_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned OFF_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             entry_i,
  input  logic [1:0]       cause_i,
  input  logic             pf_abort_i,
  input  logic             dbg_instr_i,
  input  logic             sys_instr_i,
  input  logic             sys_abort_i,
  output logic [OFF_W-1:0] offset_o,
  output logic             offset_valid_o,
  output logic             entry_o,
  output logic             abort_req_o
);
  localparam int unsigned NumCnt = 2;

  logic              accept;
  cause_e            cause_q;
  logic [NumCnt-1:0] inc, sat_hit;
  logic [CNT_W-1:0]  cnt [NumCnt];
  logic              ovf_q;

  assign inc = {sys_instr_i, dbg_instr_i};

  dbg_entry_ctrl u_entry (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .entry_i    (entry_i),
    .cause_i    (cause_i),
    .pf_abort_i (pf_abort_i),
    .accept_o   (accept),
    .cause_q_o  (cause_q),
    .entry_o    (entry_o)
  );

  // index 0: debug-speed count, index 1: system-speed count
  for (genvar i = 0; i < NumCnt; i++) begin : g_cnt
    dbg_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (accept),
      .inc_i     (inc[i]),
      .cnt_o     (cnt[i]),
      .sat_hit_o (sat_hit[i])
    );
  end

  dbg_offset_calc #(.CNT_W(CNT_W), .OFF_W(OFF_W)) u_calc (
    .cause_i  (cause_q),
    .n_i      (cnt[0]),
    .s_i      (cnt[1]),
    .offset_o (offset_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q       <= 1'b0;
      abort_req_o <= 1'b0;
    end else begin
      abort_req_o <= sys_instr_i && sys_abort_i;
      if (accept)          ovf_q <= 1'b0;
      else if (|sat_hit)   ovf_q <= 1'b1;
    end
  end

  assign offset_valid_o = !ovf_q;
endmodule

// File: rtl/dbg_ret_tracker_chk.sv
module dbg_ret_tracker_chk #(
  parameter int unsigned OFF_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             entry_i,
  input logic [1:0]       cause_i,
  input logic             pf_abort_i,
  input logic             dbg_instr_i,
  input logic             sys_instr_i,
  input logic             sys_abort_i,
  input logic [OFF_W-1:0] offset_o,
  input logic             offset_valid_o,
  input logic             entry_o,
  input logic             abort_req_o
);
  logic acc;
  assign acc = entry_i && !(pf_abort_i && cause_i == 2'b00);

  a_r1_entry_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> entry_o);

  a_r1_clear_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !cause_i[1] |=> offset_o == {{(OFF_W-3){1'b1}}, 3'b100});

  a_r3_clear_async: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && cause_i[1] |=> offset_o == {OFF_W{1'b1}} - OFF_W'(2));

  a_r5_bkpt_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_i && pf_abort_i && cause_i == 2'b00 |=> !entry_o);

  a_r4_hold_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !entry_i && !dbg_instr_i && !sys_instr_i |=> $stable(offset_o));

  a_r6_abort_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_instr_i && sys_abort_i |=> abort_req_o);

  a_r6_abort_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sys_instr_i && sys_abort_i) |=> !abort_req_o);

  a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !offset_valid_o && !acc |=> !offset_valid_o);
endmodule

bind dbg_ret_tracker dbg_ret_tracker_chk #(.OFF_W(OFF_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .entry_i        (entry_i),
  .cause_i        (cause_i),
  .pf_abort_i     (pf_abort_i),
  .dbg_instr_i    (dbg_instr_i),
  .sys_instr_i    (sys_instr_i),
  .sys_abort_i    (sys_abort_i),
  .offset_o       (offset_o),
  .offset_valid_o (offset_valid_o),
  .entry_o        (entry_o),
  .abort_req_o    (abort_req_o)
);

// File: tb/tb_dbg_ret_tracker.sv
module tb_dbg_ret_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        entry = 1'b0;
  logic [1:0]  cause = 2'b00;
  logic        pf_abort = 1'b0;
  logic        dbg_instr = 1'b0;
  logic        sys_instr = 1'b0;
  logic        sys_abort = 1'b0;
  logic [31:0] offset;
  logic        offset_valid, entry_o, abort_req;

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 0;

  // behavioural reference
  int m_n = 0, m_s = 0, m_cause = 0;
  bit m_ovf = 0, m_entry = 0, m_abort = 0;

  always #2.5 clk = ~clk;

  dbg_ret_tracker dut (
    .clk_i(clk), .rst_ni(rst_n), .entry_i(entry), .cause_i(cause),
    .pf_abort_i(pf_abort), .dbg_instr_i(dbg_instr), .sys_instr_i(sys_instr),
    .sys_abort_i(sys_abort), .offset_o(offset), .offset_valid_o(offset_valid),
    .entry_o(entry_o), .abort_req_o(abort_req)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_n = 0; m_s = 0; m_cause = 0; m_ovf = 0; m_entry = 0; m_abort = 0;
    end else begin
      bit acc;
      acc = entry && !(cause == 2'b00 && pf_abort);
      m_entry = acc;
      m_abort = sys_instr && sys_abort;
      if (acc) begin
        m_n = 0; m_s = 0; m_ovf = 0; m_cause = int'(cause);
      end else begin
        if (dbg_instr) begin if (m_n == 255) m_ovf = 1; else m_n++; end
        if (sys_instr) begin if (m_s == 255) m_ovf = 1; else m_s++; end
      end
    end
  end

  function automatic logic [31:0] exp_offset();
    int base;
    base = (m_cause >= 2) ? 3 : 4;
    return 32'(0 - (base + m_n + 3 * m_s));
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, act, exp);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      check(m_cause >= 2 ? "R3 R4 offset" : "R2 R4 offset", offset, exp_offset());
      check("R7 offset_valid", 32'(offset_valid), 32'(!m_ovf));
      check("R1 R5 R9 entry_o", 32'(entry_o), 32'(m_entry));
      check("R6 abort_req", 32'(abort_req), 32'(m_abort));
    end
  end

  task automatic step(bit e, logic [1:0] c, bit pf, bit di, bit si, bit sa);
    @(negedge clk);
    entry = e; cause = c; pf_abort = pf;
    dbg_instr = di; sys_instr = si; sys_abort = sa;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) step(0, 2'b00, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 reset offset", offset, 32'hFFFF_FFFC);
    check("R8 reset entry_o", 32'(entry_o), 32'd0);
    check("R8 reset abort_req", 32'(abort_req), 32'd0);
    check("R8 reset valid", 32'(offset_valid), 32'd1);
    rst_n = 1'b1;
    idle(2);
    // R1 R2 breakpoint then mixed strobes (R4)
    step(1, 2'b00, 0, 0, 0, 0);
    step(0, 2'b00, 0, 1, 0, 0);
    step(0, 2'b00, 0, 1, 1, 0);
    step(0, 2'b00, 0, 0, 1, 0);
    idle(2);
    // R6 aborted system access, and abort flag alone ignored
    step(0, 2'b00, 0, 0, 1, 1);
    step(0, 2'b00, 0, 0, 0, 1);
    idle(2);
    // R3 debug request, watchpoint with exception
    step(1, 2'b10, 0, 0, 0, 0);
    step(0, 2'b00, 0, 1, 1, 0);
    step(1, 2'b11, 0, 0, 0, 0);
    step(0, 2'b00, 0, 0, 1, 0);
    // R5 breakpoint with prefetch abort dropped, watchpoint with it accepted
    step(1, 2'b00, 1, 0, 0, 0);
    idle(2);
    step(1, 2'b01, 1, 0, 0, 0);
    step(0, 2'b00, 0, 1, 0, 0);
    // R9 entry with strobes in the same cycle
    step(1, 2'b10, 0, 1, 1, 0);
    idle(2);
    // R7 saturate N, then S, then clear on entry
    step(1, 2'b00, 0, 0, 0, 0);
    for (int i = 0; i < 258; i++) step(0, 2'b00, 0, 1, 0, 0);
    idle(2);
    step(1, 2'b01, 0, 0, 0, 0);
    for (int i = 0; i < 257; i++) step(0, 2'b00, 0, 0, 1, i[0]);
    idle(2);
    step(1, 2'b11, 0, 0, 0, 0);
    idle(2);
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      step(r < 3, 2'($urandom_range(0, 3)), $urandom_range(0, 3) == 0,
           $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0,
           $urandom_range(0, 3) == 0);
    end
    idle(3);
    finish_run();
  end
endmodule